// File: doc/BRIEF.md
# RF Front-End Command Sequencer

This block runs short microprograms that steer the control registers of a radio front end around transmit and receive events. Programs live in a small command memory as 16-bit commands, two per 32-bit word, with the lower halfword of each word run before the upper one. A one-cycle trigger pulse picks one of three entry points and launches the program stored there. The program then runs to completion with no further help.

The sequencer has one working register. A command can load that register from a register-bank byte offset or store it back to one. A command can also clear or set a single bit of it, stall for a number of microseconds, or fill it from a calibration table. There is one calibration table indexed by channel and a second indexed by power level. The register bank and the calibration tables sit outside the block. Each is reached through a single-cycle strobe, and it answers combinationally during that strobe. A program stops at its end command. It is also cut short with an error if its opcode is unknown or if it runs past the per-sequence command limit.

Top module: `rfseq`

## Requirements
- R1: After reset `busy`, `err`, `rb_re`, `rb_we` and `cal_re` are all low.
- R2: When idle, a `trig` pulse with `trig_sel` 0, 1 or 2 starts execution at the low halfword of word `entry0`, `entry1` or `entry2`. The low halfword runs before the high halfword, and then the next word follows. A `trig_sel` of 3 starts nothing.
- R3: A command with top nibble 0x1 pulses `rb_re` with `rb_addr` = cmd[10:0] and loads `rb_rdata` into the working register. A command with top nibble 0x2 pulses `rb_we` for one cycle with `rb_addr` = cmd[10:0] and `rb_wdata` = the working register.
- R4: Top nibble 0x3 clears bit cmd[3:0] of the 16-bit working register. Top nibble 0x4 sets that bit. Every other bit is left unchanged.
- R5: Top nibble 0x5 stalls for N = cmd[11:0] microseconds, where one microsecond is CLK_PER_US clocks. Take a write, then that stall, then a write: the two `rb_we` pulses are 4 + N*CLK_PER_US cycles apart, so N = 0 gives 4.
- R6: Command 0x6000 pulses `cal_re` with `cal_addr` = `vco_base` + `chan_idx` (modulo 2^CAW) and loads `cal_rdata` into the working register.
- R7: Command 0x7000 reads `cal_addr` = `pwr_base` + 2*`pwr_idx`. Command 0x8000 reads that address plus one. Both are modulo 2^CAW and both load the working register.
- R8: Command 0xF000 ends the sequence. `busy`, high since the cycle after the trigger, drops and `err` stays low.
- R9: Top nibbles 0x0 and 0x9 to 0xE end the sequence with `err` high. No later command runs. `err` stays set until the next accepted trigger clears it.
- R10: A sequence may hold up to MAX_CMDS (128) commands, and the last of those may be the end command. If MAX_CMDS commands run without an end, the sequence stops with `err` high before the next command.
- R11: A trigger that arrives while `busy` is high is ignored. The running sequence and its outputs are unchanged.
- R12: At most one of `rb_re`, `rb_we` and `cal_re` is high in any cycle, and none of them is high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Command memory write enable |
| prog_addr | input | AW | Command memory word address |
| prog_data | input | 32 | Command word: first command low, second high |
| entry0 | input | AW | Start word of sequence 0 |
| entry1 | input | AW | Start word of sequence 1 |
| entry2 | input | AW | Start word of sequence 2 |
| trig | input | 1 | Launch pulse |
| trig_sel | input | 2 | Sequence to launch (3 = none) |
| vco_base | input | CAW | Base of the per-channel table |
| chan_idx | input | CAW | Channel index |
| pwr_base | input | CAW | Base of the per-power table |
| pwr_idx | input | CAW | Power index |
| rb_re | output | 1 | Register read strobe |
| rb_we | output | 1 | Register write strobe |
| rb_addr | output | 11 | Register byte offset |
| rb_wdata | output | DW | Register write data |
| rb_rdata | input | DW | Register read data, valid during `rb_re` |
| cal_re | output | 1 | Calibration read strobe |
| cal_addr | output | CAW | Calibration table address |
| cal_rdata | input | DW | Calibration data, valid during `cal_re` |
| busy | output | 1 | Sequence running |
| err | output | 1 | Last sequence aborted |

## Verification
The assertions take three things for granted. The register bank and the calibration tables answer within the same cycle as the strobe. The command memory is rewritten only while `busy` is low. A stall command is never issued while the microsecond timer is still counting. The bench keeps within these assumptions in three ways. Its memory models are combinational functions of the address. It loads every program before launching it. Each sequence is allowed to end before the next program is written. The only out-of-pattern stimulus is deliberate: triggers while busy, the unused select value, and the illegal opcode classes.

// File: rtl/rfseq_pkg.sv
package rfseq_pkg;
  localparam int OFS_W  = 11;
  localparam int WAIT_W = 12;

  typedef enum logic [3:0] {
    OP_BAD, OP_RD, OP_WR, OP_CLR, OP_SET, OP_WAIT,
    OP_VCO, OP_DCC, OP_DCO, OP_END
  } op_t;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_EXEC, S_RDRB, S_RDCAL, S_STALL
  } st_t;
endpackage

// File: rtl/rfseq_cmd_ram.sv
module rfseq_cmd_ram #(
  parameter int DEPTH = 64,
  parameter int WW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [WW-1:0] rdata
);
  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rfseq_decode.sv
module rfseq_decode
  import rfseq_pkg::*;
(
  input  logic [15:0]       cmd,
  output op_t               op,
  output logic [OFS_W-1:0]  ofs,
  output logic [WAIT_W-1:0] nwait
);
  assign ofs   = cmd[OFS_W-1:0];
  assign nwait = cmd[WAIT_W-1:0];

  always_comb begin
    unique case (cmd[15:12])
      4'h1:    op = OP_RD;
      4'h2:    op = OP_WR;
      4'h3:    op = OP_CLR;
      4'h4:    op = OP_SET;
      4'h5:    op = OP_WAIT;
      4'h6:    op = OP_VCO;
      4'h7:    op = OP_DCC;
      4'h8:    op = OP_DCO;
      4'hF:    op = OP_END;
      default: op = OP_BAD;
    endcase
  end
endmodule

// File: rtl/rfseq_us_timer.sv
module rfseq_us_timer #(
  parameter int CLK_PER_US = 4,
  parameter int CW         = 12,
  localparam int PW        = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] count,
  output logic          done
);
  localparam logic [PW-1:0] PRE_TOP = PW'(CLK_PER_US - 1);

  logic          run;
  logic [PW-1:0] pre;
  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      pre  <= '0;
      left <= '0;
    end else if (start) begin
      run  <= 1'b1;
      pre  <= PRE_TOP;
      left <= count;
    end else if (run) begin
      if (pre == '0) begin
        pre  <= PRE_TOP;
        left <= left - 1'b1;
        if (left == CW'(1)) run <= 1'b0;
      end else begin
        pre <= pre - 1'b1;
      end
    end
  end

  assign done = run && (pre == '0) && (left == CW'(1));

  // R5: a running countdown never holds a zero microsecond count
  a_r5_left_nonzero: assert property (@(posedge clk) disable iff (rst)
    run |-> (left != '0));
  // R5: a stall is never launched on top of one still counting
  a_r5_no_restart: assert property (@(posedge clk) disable iff (rst)
    start |-> !run);
endmodule

// File: rtl/rfseq.sv
module rfseq
  import rfseq_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int DW         = 16,
  parameter int CAW        = 8,
  parameter int CLK_PER_US = 4,
  parameter int MAX_CMDS   = 128,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             prog_we,
  input  logic [AW-1:0]    prog_addr,
  input  logic [31:0]      prog_data,
  input  logic [AW-1:0]    entry0,
  input  logic [AW-1:0]    entry1,
  input  logic [AW-1:0]    entry2,
  input  logic             trig,
  input  logic [1:0]       trig_sel,
  input  logic [CAW-1:0]   vco_base,
  input  logic [CAW-1:0]   chan_idx,
  input  logic [CAW-1:0]   pwr_base,
  input  logic [CAW-1:0]   pwr_idx,
  output logic             rb_re,
  output logic             rb_we,
  output logic [OFS_W-1:0] rb_addr,
  output logic [DW-1:0]    rb_wdata,
  input  logic [DW-1:0]    rb_rdata,
  output logic             cal_re,
  output logic [CAW-1:0]   cal_addr,
  input  logic [DW-1:0]    cal_rdata,
  output logic             busy,
  output logic             err
);
  localparam int BW = $clog2(DW);
  localparam int NW = $clog2(MAX_CMDS + 1);
  localparam logic [NW-1:0] NMAX = NW'(MAX_CMDS);

  st_t               st;
  logic [AW:0]       pc;
  logic [NW-1:0]     ncmd;
  logic [DW-1:0]     wreg;
  logic [31:0]       word;
  logic [15:0]       cmd;
  op_t               op;
  logic [OFS_W-1:0]  ofs;
  logic [WAIT_W-1:0] nwait;
  logic [BW-1:0]     bidx;
  logic              at_limit;
  logic              tmr_start;
  logic              tmr_done;
  logic [AW-1:0]     entry_sel;
  logic [CAW-1:0]    pwr_row;

  rfseq_cmd_ram #(.DEPTH(DEPTH), .WW(32)) u_ram (
    .clk(clk), .we(prog_we), .waddr(prog_addr), .wdata(prog_data),
    .raddr(pc[AW:1]), .rdata(word)
  );

  assign cmd  = pc[0] ? word[31:16] : word[15:0];
  assign bidx = cmd[BW-1:0];

  rfseq_decode u_dec (.cmd(cmd), .op(op), .ofs(ofs), .nwait(nwait));

  assign at_limit  = (ncmd == NMAX);
  assign tmr_start = (st == S_EXEC) && !at_limit && (op == OP_WAIT) && (nwait != '0);

  rfseq_us_timer #(.CLK_PER_US(CLK_PER_US), .CW(WAIT_W)) u_tmr (
    .clk(clk), .rst(rst), .start(tmr_start), .count(nwait), .done(tmr_done)
  );

  always_comb begin
    unique case (trig_sel)
      2'd0:    entry_sel = entry0;
      2'd1:    entry_sel = entry1;
      default: entry_sel = entry2;
    endcase
  end

  assign pwr_row = {pwr_idx[CAW-2:0], 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      pc       <= '0;
      ncmd     <= '0;
      wreg     <= '0;
      busy     <= 1'b0;
      err      <= 1'b0;
      rb_re    <= 1'b0;
      rb_we    <= 1'b0;
      cal_re   <= 1'b0;
      rb_addr  <= '0;
      rb_wdata <= '0;
      cal_addr <= '0;
    end else begin
      rb_re  <= 1'b0;
      rb_we  <= 1'b0;
      cal_re <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (trig && (trig_sel != 2'd3)) begin
            pc   <= {entry_sel, 1'b0};
            ncmd <= '0;
            busy <= 1'b1;
            err  <= 1'b0;
            st   <= S_FETCH;
          end
        end
        S_FETCH: st <= S_EXEC;
        S_EXEC: begin
          if (at_limit) begin
            busy <= 1'b0;
            err  <= 1'b1;
            st   <= S_IDLE;
          end else begin
            ncmd <= ncmd + 1'b1;
            unique case (op)
              OP_RD: begin
                rb_re   <= 1'b1;
                rb_addr <= ofs;
                st      <= S_RDRB;
              end
              OP_WR: begin
                rb_we    <= 1'b1;
                rb_addr  <= ofs;
                rb_wdata <= wreg;
                pc       <= pc + 1'b1;
                st       <= S_FETCH;
              end
              OP_CLR: begin
                wreg[bidx] <= 1'b0;
                pc         <= pc + 1'b1;
                st         <= S_FETCH;
              end
              OP_SET: begin
                wreg[bidx] <= 1'b1;
                pc         <= pc + 1'b1;
                st         <= S_FETCH;
              end
              OP_WAIT: begin
                if (nwait == '0) begin
                  pc <= pc + 1'b1;
                  st <= S_FETCH;
                end else begin
                  st <= S_STALL;
                end
              end
              OP_VCO: begin
                cal_re   <= 1'b1;
                cal_addr <= vco_base + chan_idx;
                st       <= S_RDCAL;
              end
              OP_DCC: begin
                cal_re   <= 1'b1;
                cal_addr <= pwr_base + pwr_row;
                st       <= S_RDCAL;
              end
              OP_DCO: begin
                cal_re   <= 1'b1;
                cal_addr <= pwr_base + pwr_row + CAW'(1);
                st       <= S_RDCAL;
              end
              OP_END: begin
                busy <= 1'b0;
                st   <= S_IDLE;
              end
              default: begin
                busy <= 1'b0;
                err  <= 1'b1;
                st   <= S_IDLE;
              end
            endcase
          end
        end
        S_RDRB: begin
          wreg <= rb_rdata;
          pc   <= pc + 1'b1;
          st   <= S_FETCH;
        end
        S_RDCAL: begin
          wreg <= cal_rdata;
          pc   <= pc + 1'b1;
          st   <= S_FETCH;
        end
        S_STALL: begin
          if (tmr_done) begin
            pc <= pc + 1'b1;
            st <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R12: strobes are exclusive
  a_r12_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rb_re, rb_we, cal_re}));
  // R12: no strobe outside a running sequence
  a_r12_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(rb_re || rb_we || cal_re));
  // R3: register access strobes last exactly one cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (rb_re || rb_we) |=> !(rb_re || rb_we));
  // R9: an error appears only at the moment a sequence stops
  a_r9_err_at_stop: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> $fell(busy));
  // R10: the command count never exceeds the limit
  a_r10_count_bound: assert property (@(posedge clk) disable iff (rst)
    ncmd <= NMAX);
  // R11: a trigger during a running sequence does not restart it
  a_r11_no_relaunch: assert property (@(posedge clk) disable iff (rst)
    (busy && st != S_IDLE && trig) |=> (ncmd >= $past(ncmd)));
endmodule

// File: tb/rfseq_bench.sv
`timescale 1ns/1ps
module rfseq_bench;
  localparam int DEPTH = 64;
  localparam int DW    = 16;
  localparam int CAW   = 8;
  localparam int K     = 4;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic           prog_we = 1'b0;
  logic [AW-1:0]  prog_addr = '0;
  logic [31:0]    prog_data = '0;
  logic [AW-1:0]  entry0 = 6'd0, entry1 = 6'd20, entry2 = 6'd40;
  logic           trig = 1'b0;
  logic [1:0]     trig_sel = 2'd0;
  logic [CAW-1:0] vco_base = 8'h20, chan_idx = 8'h0, pwr_base = 8'hF9, pwr_idx = 8'h0;
  logic           rb_re, rb_we, cal_re, busy, err;
  logic [10:0]    rb_addr;
  logic [DW-1:0]  rb_wdata, rb_rdata, cal_rdata;
  logic [CAW-1:0] cal_addr;

  function automatic logic [15:0] rbval(input logic [10:0] a);
    return 16'h5A00 ^ ({5'd0, a} * 16'h0137);
  endfunction
  function automatic logic [15:0] calval(input logic [7:0] a);
    return {a, ~a};
  endfunction

  assign rb_rdata  = rbval(rb_addr);
  assign cal_rdata = calval(cal_addr);

  rfseq #(.DEPTH(DEPTH), .DW(DW), .CAW(CAW), .CLK_PER_US(K), .MAX_CMDS(128)) u_rfseq (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
    .entry0(entry0), .entry1(entry1), .entry2(entry2), .trig(trig), .trig_sel(trig_sel),
    .vco_base(vco_base), .chan_idx(chan_idx), .pwr_base(pwr_base), .pwr_idx(pwr_idx),
    .rb_re(rb_re), .rb_we(rb_we), .rb_addr(rb_addr), .rb_wdata(rb_wdata), .rb_rdata(rb_rdata),
    .cal_re(cal_re), .cal_addr(cal_addr), .cal_rdata(cal_rdata), .busy(busy), .err(err)
  );

  int total = 0, bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int          nlog = 0;
  logic [10:0] log_a [64];
  logic [15:0] log_d [64];
  int          log_t [64];
  always @(negedge clk) begin
    if (rb_we && nlog < 64) begin
      log_a[nlog] = rb_addr;
      log_d[nlog] = rb_wdata;
      log_t[nlog] = cyc;
      nlog = nlog + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [15:0] cb [128];
  int ncb = 0;
  task automatic push(input logic [15:0] c);
    cb[ncb] = c;
    ncb++;
  endtask
  task automatic load(input int base);
    if (ncb % 2 == 1) push(16'hF000);
    for (int i = 0; i < ncb / 2; i++) begin
      @(negedge clk);
      prog_we   = 1'b1;
      prog_addr = AW'(base + i);
      prog_data = {cb[2*i+1], cb[2*i]};
    end
    @(negedge clk);
    prog_we = 1'b0;
    ncb = 0;
  endtask

  function automatic logic [15:0] c_rd(input int o);  return 16'h1800 + 16'(o); endfunction
  function automatic logic [15:0] c_wr(input int o);  return 16'h2800 + 16'(o); endfunction
  function automatic logic [15:0] c_clr(input int b); return 16'h3000 + 16'(b); endfunction
  function automatic logic [15:0] c_set(input int b); return 16'h4000 + 16'(b); endfunction
  function automatic logic [15:0] c_wt(input int n);  return 16'h5000 + 16'(n); endfunction

  function automatic int base_of(input int sel);
    return (sel == 0) ? 0 : (sel == 1) ? 20 : 40;
  endfunction

  task automatic launch(input int sel);
    nlog = 0;
    @(negedge clk);
    trig = 1'b1;
    trig_sel = 2'(sel);
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic settle(input string req);
    int n = 0;
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(req, {31'd0, busy}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 err", {31'd0, err}, 0);
    chk("R1 strobes", {29'd0, rb_re, rb_we, cal_re}, 0);

    // R2: trig_sel 3 launches nothing
    launch(3);
    repeat (3) @(negedge clk);
    chk("R2 sel3 busy", {31'd0, busy}, 0);
    chk("R2 sel3 writes", nlog, 0);

    // R3 R4 R2: bit sweep, rotating entry points
    for (int b = 0; b < 16; b++) begin
      int sel = b % 3;
      logic [15:0] v;
      v = rbval(11'(64 + b));
      push(c_rd(64 + b)); push(c_set(b)); push(c_wr(256)); push(c_clr(b)); push(c_wr(257));
      load(base_of(sel));
      launch(sel);
      chk("R8 busy after trigger", {31'd0, busy}, 1);
      settle("R8 end");
      chk("R8 err", {31'd0, err}, 0);
      chk("R2 write count", nlog, 2);
      chk("R3 write addr0", {21'd0, log_a[0]}, 256);
      chk("R4 set bit", {16'd0, log_d[0]}, {16'd0, v | (16'd1 << b)});
      chk("R3 write addr1", {21'd0, log_a[1]}, 257);
      chk("R4 clear bit", {16'd0, log_d[1]}, {16'd0, v & ~(16'd1 << b)});
    end

    // R5: stall sweep
    for (int i = 0; i < 9; i++) begin
      int n = (i < 8) ? i : 255;
      push(c_wr(48)); push(c_wt(n)); push(c_wr(49));
      load(base_of(1));
      launch(1);
      settle("R5 end");
      chk("R5 writes", nlog, 2);
      chk("R5 gap", log_t[1] - log_t[0], 4 + n * K);
    end

    // R6 R7: calibration sweep with address wrap
    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p < 4; p++) begin
        logic [7:0] a6, a7, a8;
        chan_idx = 8'(c * 37 + 200);
        pwr_idx  = 8'(p);
        a6 = vco_base + chan_idx;
        a7 = pwr_base + 8'(2 * p);
        a8 = a7 + 8'd1;
        push(16'h6000); push(c_wr(80)); push(16'h7000); push(c_wr(81));
        push(16'h8000); push(c_wr(82));
        load(base_of(2));
        launch(2);
        settle("R6 end");
        chk("R6 vco", {16'd0, log_d[0]}, {16'd0, calval(a6)});
        chk("R7 coef", {16'd0, log_d[1]}, {16'd0, calval(a7)});
        chk("R7 offs", {16'd0, log_d[2]}, {16'd0, calval(a8)});
      end
    end

    // R9: every illegal class aborts, next launch clears err
    for (int k = 0; k < 7; k++) begin
      logic [3:0] cls;
      cls = (k == 0) ? 4'h0 : 4'(8 + k);
      push(c_wr(16)); push({cls, 12'h123}); push(c_wr(17));
      load(base_of(0));
      launch(0);
      settle("R9 end");
      chk("R9 err", {31'd0, err}, 1);
      chk("R9 writes", nlog, 1);
      push(c_wr(18));
      load(base_of(0));
      launch(0);
      settle("R9 clear end");
      chk("R9 err cleared", {31'd0, err}, 0);
    end

    // R11: trigger during a stall is ignored
    push(c_wr(112)); push(c_wt(20)); push(c_wr(113));
    load(base_of(1));
    push(c_wr(120));
    load(base_of(0));
    launch(1);
    repeat (20) @(negedge clk);
    trig = 1'b1; trig_sel = 2'd0;
    @(negedge clk);
    trig = 1'b0;
    settle("R11 end");
    repeat (4) @(negedge clk);
    chk("R11 still idle", {31'd0, busy}, 0);
    chk("R11 writes", nlog, 2);
    chk("R11 first", {21'd0, log_a[0]}, 112);
    chk("R11 second", {21'd0, log_a[1]}, 113);

    // R10: limit of 128 commands
    for (int i = 0; i < 126; i++) push(c_set(0));
    push(c_wr(96)); push(16'hF000);
    load(0);
    launch(0);
    settle("R10 end");
    chk("R10 end at 128 err", {31'd0, err}, 0);
    chk("R10 end at 128 writes", nlog, 1);
    for (int i = 0; i < 126; i++) push(c_set(0));
    push(c_wr(96)); push(c_wr(97));
    load(0);
    launch(0);
    settle("R10 overrun end");
    chk("R10 overrun err", {31'd0, err}, 1);
    chk("R10 overrun writes", nlog, 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule